// File: doc/BRIEF.md
# Transport Stream Packet Output Formatter

This block sits after the error-correction stage of a broadcast receiver. It accepts decoded transport stream packets of fixed length on a byte-wide valid/ready stream. Each packet carries a flag that reports whether the decoder found bytes it could not correct. The block stores one whole packet, then sends it as an unbroken burst of bytes on a parallel output. Three strobes go with the burst: start, valid and an active-low error strobe.

When marking is enabled, the block also rewrites the transport-error-indicator bit in the header of every uncorrectable packet as the bytes leave. An active-low output enable gates the whole output side. Clearing it stops the current burst at once and drops that packet. A build parameter selects the clock edge that launches the outputs. The default launches them on the falling edge, so they are settled at the rising edge.

Input back-pressure rules:
- A byte transfers on any rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` drops once a complete packet is stored. It stays low until that packet has been fully sent or dropped.
- The source may hold `in_valid` low for any time between bytes.

Top module: `ts_out_formatter`

## Requirements
- R1: A stored packet leaves as exactly `PKT_BYTES` (188) bytes on consecutive cycles, in the order received, with no idle cycle inside the burst.
- R2: Whenever `out_valid` is low, `out_data` is all zeros, `out_start` is low and `out_err_n` is high.
- R3: `out_start` is high only on the cycle that carries byte 0 of a burst.
- R4: `out_valid` is high from byte 0 through the last byte of a burst and low otherwise; a burst never runs longer than `PKT_BYTES`.
- R5: If any input byte of a packet had `in_err` high, `out_err_n` is low on every byte of that packet's burst; for a clean packet it stays high throughout.
- R6: With `tei_en` = 1, for a packet flagged uncorrectable, bit 7 of byte index 1 is output as 1; every other bit and byte is unchanged.
- R7: With `tei_en` = 0, byte index 1 passes through unchanged, so an input value of 1 in bit 7 still leaves as 1; clean packets are never modified whatever `tei_en` is.
- R8: While `out_en_n` is 1 the outputs are idle (data 0, start 0, valid 0, error strobe 1) from two cycles later. A burst cut short this way is dropped and never resumed.
- R9: Input bytes are taken only when `in_valid` and `in_ready` are both high. `in_sop` marks byte 0, and bytes before it are discarded. `in_ready` is low while a complete packet waits or is being sent, including while output is disabled.
- R10: After reset the outputs are idle and `in_ready` is high.
- R11: With `LAUNCH_ON_FALL` = 1, the outputs change only at falling clock edges, so their values are equal just before and just after each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en_n | input | 1 | Active-low output enable |
| tei_en | input | 1 | Enable error-indicator marking of uncorrectable packets |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Formatter can take a byte |
| in_data | input | DATA_W | Input byte |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_err | input | 1 | Packet holds uncorrectable bytes (OR-ed over the packet) |
| out_data | output | DATA_W | Output byte, zero in gaps |
| out_start | output | 1 | First byte of a burst |
| out_valid | output | 1 | Burst in progress |
| out_err_n | output | 1 | Active-low uncorrectable-packet strobe |

## Verification
The bench builds the block with its defaults: 188-byte packets, 8-bit data, marking at bit 7 of byte index 1, and falling-edge launch. Full-length packets therefore reach the last-byte boundary of the read counter and the header byte that is rewritten. The falling-edge default is the variant whose outputs the bench checks around the rising edge. Shorter packet lengths and rising-edge launch are legal parameter settings, but the bench does not build them.

// File: rtl/ts_fmt_pkg.sv
`timescale 1ns/1ps
package ts_fmt_pkg;
  localparam int unsigned TS_PKT_BYTES = 188;
  localparam int unsigned TS_BYTE_W    = 8;
  localparam int unsigned TS_MARK_IDX  = 1;
  localparam int unsigned TS_MARK_BIT  = 7;

  typedef enum logic [1:0] {
    FL_HUNT = 2'd0,
    FL_LOAD = 2'd1,
    FL_HELD = 2'd2
  } fill_state_e;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_SEND = 1'b1
  } drain_state_e;
endpackage

// File: rtl/ts_fill_ctrl.sv
`timescale 1ns/1ps
module ts_fill_ctrl
  import ts_fmt_pkg::*;
#(
  parameter int unsigned PKT_BYTES = TS_PKT_BYTES,
  parameter int unsigned PTR_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_err,
  input  logic             release_i,
  output logic             in_ready,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             held,
  output logic             pkt_bad
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(PKT_BYTES - 1);

  fill_state_e      state;
  logic [PTR_W-1:0] cnt;
  logic             err_acc;
  logic             take;

  assign in_ready = (state != FL_HELD);
  assign take     = in_valid && in_ready;
  assign wr_en    = take && (in_sop || state == FL_LOAD);
  assign wr_idx   = in_sop ? '0 : cnt;
  assign held     = (state == FL_HELD);

  // A start-of-packet byte always restarts the fill; stray bytes while hunting are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FL_HUNT;
      cnt     <= '0;
      err_acc <= 1'b0;
      pkt_bad <= 1'b0;
    end else begin
      if (take && in_sop) begin
        state   <= FL_LOAD;
        cnt     <= PTR_W'(1);
        err_acc <= in_err;
      end else if (take && state == FL_LOAD) begin
        err_acc <= err_acc | in_err;
        if (cnt == LAST_IDX) begin
          state   <= FL_HELD;
          pkt_bad <= err_acc | in_err;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (state == FL_HELD && release_i) begin
        state <= FL_HUNT;
      end
    end
  end
endmodule

// File: rtl/ts_pkt_ram.sv
`timescale 1ns/1ps
module ts_pkt_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 188,
  parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ts_drain_seq.sv
`timescale 1ns/1ps
module ts_drain_seq
  import ts_fmt_pkg::*;
#(
  parameter int unsigned DATA_W    = TS_BYTE_W,
  parameter int unsigned PKT_BYTES = TS_PKT_BYTES,
  parameter int unsigned PTR_W     = $clog2(PKT_BYTES),
  parameter int unsigned MARK_IDX  = TS_MARK_IDX,
  parameter int unsigned MARK_BIT  = TS_MARK_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en_n,
  input  logic              tei_en,
  input  logic              held,
  input  logic              pkt_bad,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_idx,
  output logic              release_o,
  output logic [DATA_W-1:0] nx_data,
  output logic              nx_start,
  output logic              nx_valid,
  output logic              nx_err_n
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(PKT_BYTES - 1);
  localparam logic [PTR_W-1:0] MARK_AT  = PTR_W'(MARK_IDX);

  drain_state_e      state;
  logic [PTR_W-1:0]  idx;
  logic              live;
  logic              mark;
  logic [DATA_W-1:0] byte_v;

  assign rd_idx    = idx;
  assign live      = (state == DR_SEND) && !out_en_n;
  assign mark      = live && tei_en && pkt_bad && (idx == MARK_AT);
  assign release_o = (state == DR_SEND) && (out_en_n || idx == LAST_IDX);

  // Error-indicator rewrite: one bit OR-ed to 1, every other bit untouched.
  always_comb begin
    byte_v = rd_data;
    if (mark) byte_v[MARK_BIT] = 1'b1;
  end

  assign nx_data  = live ? byte_v : '0;
  assign nx_start = live && (idx == '0);
  assign nx_valid = live;
  assign nx_err_n = !(live && pkt_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DR_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        DR_IDLE: begin
          if (held && !out_en_n) begin
            state <= DR_SEND;
            idx   <= '0;
          end
        end
        default: begin
          if (out_en_n || idx == LAST_IDX) begin
            state <= DR_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ts_launch_stage.sv
`timescale 1ns/1ps
module ts_launch_stage #(
  parameter int unsigned DATA_W         = 8,
  parameter bit          LAUNCH_ON_FALL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] nx_data,
  input  logic              nx_start,
  input  logic              nx_valid,
  input  logic              nx_err_n,
  output logic [DATA_W-1:0] q_data,
  output logic              q_start,
  output logic              q_valid,
  output logic              q_err_n
);
  generate
    if (LAUNCH_ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_data <= '0; q_start <= 1'b0; q_valid <= 1'b0; q_err_n <= 1'b1;
        end else begin
          q_data <= nx_data; q_start <= nx_start; q_valid <= nx_valid; q_err_n <= nx_err_n;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_data <= '0; q_start <= 1'b0; q_valid <= 1'b0; q_err_n <= 1'b1;
        end else begin
          q_data <= nx_data; q_start <= nx_start; q_valid <= nx_valid; q_err_n <= nx_err_n;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ts_out_formatter.sv
`timescale 1ns/1ps
module ts_out_formatter
  import ts_fmt_pkg::*;
#(
  parameter int unsigned DATA_W         = TS_BYTE_W,
  parameter int unsigned PKT_BYTES      = TS_PKT_BYTES,
  parameter int unsigned MARK_IDX       = TS_MARK_IDX,
  parameter int unsigned MARK_BIT       = TS_MARK_BIT,
  parameter bit          LAUNCH_ON_FALL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en_n,
  input  logic              tei_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_err,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_valid,
  output logic              out_err_n
);
  localparam int unsigned PTR_W = $clog2(PKT_BYTES);

  logic              wr_en, held, pkt_bad, release_s;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] rd_data, nx_data;
  logic              nx_start, nx_valid, nx_err_n;

  ts_fill_ctrl #(.PKT_BYTES(PKT_BYTES), .PTR_W(PTR_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_err(in_err),
    .release_i(release_s), .in_ready(in_ready), .wr_en(wr_en), .wr_idx(wr_idx),
    .held(held), .pkt_bad(pkt_bad)
  );

  ts_pkt_ram #(.DATA_W(DATA_W), .DEPTH(PKT_BYTES), .PTR_W(PTR_W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  ts_drain_seq #(
    .DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES), .PTR_W(PTR_W),
    .MARK_IDX(MARK_IDX), .MARK_BIT(MARK_BIT)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .tei_en(tei_en), .held(held),
    .pkt_bad(pkt_bad), .rd_data(rd_data), .rd_idx(rd_idx), .release_o(release_s),
    .nx_data(nx_data), .nx_start(nx_start), .nx_valid(nx_valid), .nx_err_n(nx_err_n)
  );

  ts_launch_stage #(.DATA_W(DATA_W), .LAUNCH_ON_FALL(LAUNCH_ON_FALL)) u_launch (
    .clk(clk), .rst_n(rst_n), .nx_data(nx_data), .nx_start(nx_start), .nx_valid(nx_valid),
    .nx_err_n(nx_err_n), .q_data(out_data), .q_start(out_start), .q_valid(out_valid),
    .q_err_n(out_err_n)
  );
endmodule

// File: rtl/ts_out_formatter_chk.sv
`timescale 1ns/1ps
module ts_out_formatter_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PKT_BYTES = 188
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_en_n,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_start,
  input logic              out_valid,
  input logic              out_err_n
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= out_valid ? run_cnt + 16'd1 : 16'd0;
  end

  assert_burst_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(run_cnt) < PKT_BYTES));

  assert_gap_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && !out_start && out_err_n));

  assert_start_has_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);

  assert_no_orphan_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |-> $past(out_valid));

  assert_err_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |-> $stable(out_err_n));

  assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_en_n, 2) && $past(out_en_n)) |-> !out_valid);

  assert_ready_low_while_sending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind ts_out_formatter ts_out_formatter_chk #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .in_ready(in_ready),
  .out_data(out_data), .out_start(out_start), .out_valid(out_valid), .out_err_n(out_err_n)
);

// File: tb/ts_out_formatter_bench.sv
`timescale 1ns/1ps
module ts_out_formatter_bench;
  localparam int PKT = 188;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       out_en_n = 1'b0;
  logic       tei_en = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       in_err = 1'b0;
  logic [7:0] out_data;
  logic       out_start, out_valid, out_err_n;

  always #2.5 clk = ~clk;

  ts_out_formatter u_ts_out_formatter (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .tei_en(tei_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_err(in_err), .out_data(out_data), .out_start(out_start),
    .out_valid(out_valid), .out_err_n(out_err_n)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Output monitor: sampled 1 ns after each rising edge and 1 ns before the next.
  logic [7:0] cap [PKT];
  logic [7:0] last_pkt [PKT];
  int cur_len = 0, cur_low = 0, last_low = 0;
  int pkt_cnt = 0, trunc_cnt = 0, valid_seen = 0;
  int gap_viol = 0, start_viol = 0, long_viol = 0, edge_viol = 0;
  logic [10:0] prev_b;
  bit have_prev = 1'b0;

  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (have_prev && {out_data, out_start, out_valid, out_err_n} != prev_b) edge_viol++;
        if (out_valid) begin
          valid_seen++;
          if (out_start != (cur_len == 0)) start_viol++;
          if (cur_len >= PKT) long_viol++;
          else cap[cur_len] = out_data;
          if (!out_err_n) cur_low++;
          cur_len++;
        end else begin
          if (out_data != 8'h00 || out_start || !out_err_n) gap_viol++;
          if (cur_len == PKT) begin
            pkt_cnt++;
            for (int k = 0; k < PKT; k++) last_pkt[k] = cap[k];
            last_low = cur_low;
          end else if (cur_len != 0) begin
            trunc_cnt++;
          end
          cur_len = 0;
          cur_low = 0;
        end
      end
      #3;
      prev_b = {out_data, out_start, out_valid, out_err_n};
      have_prev = rst_n;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int k, input bit tei_in);
    if (k == 0) return 8'h47;
    if (k == 1) return {tei_in, 7'(seed)};
    return 8'(seed * 7 + k * 13);
  endfunction

  task automatic push_byte(input logic [7:0] d, input bit sop, input bit err);
    in_valid = 1'b1; in_data = d; in_sop = sop; in_err = err;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_err = 1'b0; in_data = '0;
  endtask

  task automatic send_pkt(input int seed, input bit tei_in, input bit bad);
    for (int k = 0; k < PKT; k++)
      push_byte(pat(seed, k, tei_in), k == 0, bad && k == 100);
  endtask

  task automatic wait_pkts(input int target);
    for (int i = 0; i < 3000; i++) begin
      if (pkt_cnt >= target) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic cmp_last(input int seed, input bit tei_in, input bit expect_mark,
                          input bit bad, input string req);
    int miss = 0, first = -1;
    logic [7:0] e;
    for (int k = 0; k < PKT; k++) begin
      e = pat(seed, k, tei_in);
      if (k == 1 && expect_mark) e[7] = 1'b1;
      if (last_pkt[k] !== e) begin
        miss++;
        if (first < 0) first = k;
      end
    end
    chk(miss == 0, req, "payload byte mismatches", miss, 0);
    if (first >= 0) $display("  first mismatch at byte %0d", first);
    chk(last_low == (bad ? PKT : 0), "R5", "cycles with error strobe low", last_low, bad ? PKT : 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 0 && out_start == 0 && out_data == 0 && out_err_n == 1,
        "R10", "idle outputs after reset", {out_data, out_start, out_valid, out_err_n}, 1);
    chk(in_ready == 1, "R10", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_clean_pkt;
    int base = pkt_cnt;
    tei_en = 1'b1;
    send_pkt(5, 1'b0, 1'b0);
    wait_pkts(base + 1);
    chk(pkt_cnt == base + 1, "R1", "complete bursts", pkt_cnt, base + 1);
    cmp_last(5, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_bad_marked;
    int base = pkt_cnt;
    tei_en = 1'b1;
    send_pkt(17, 1'b0, 1'b1);
    wait_pkts(base + 1);
    chk(pkt_cnt == base + 1, "R6", "complete bursts", pkt_cnt, base + 1);
    cmp_last(17, 1'b0, 1'b1, 1'b1, "R6");
  endtask

  task automatic t_bad_unmarked;
    int base = pkt_cnt;
    tei_en = 1'b0;
    send_pkt(40, 1'b0, 1'b1);
    wait_pkts(base + 1);
    cmp_last(40, 1'b0, 1'b0, 1'b1, "R7");
    send_pkt(41, 1'b1, 1'b1);
    wait_pkts(base + 2);
    cmp_last(41, 1'b1, 1'b0, 1'b1, "R7");
    tei_en = 1'b1;
  endtask

  task automatic t_clean_preset;
    int base = pkt_cnt;
    tei_en = 1'b1;
    send_pkt(66, 1'b1, 1'b0);
    wait_pkts(base + 1);
    cmp_last(66, 1'b1, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_junk_before_sop;
    int base = pkt_cnt;
    for (int j = 0; j < 5; j++) push_byte(8'hFF, 1'b0, 1'b1);
    send_pkt(33, 1'b0, 1'b0);
    wait_pkts(base + 1);
    chk(pkt_cnt == base + 1, "R9", "bursts after stray bytes", pkt_cnt, base + 1);
    cmp_last(33, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_held_while_disabled;
    int base = pkt_cnt;
    int seen = valid_seen;
    out_en_n = 1'b1;
    send_pkt(90, 1'b0, 1'b0);
    repeat (300) @(posedge clk);
    #1;
    chk(valid_seen == seen, "R8", "valid cycles while disabled", valid_seen - seen, 0);
    chk(in_ready == 0, "R9", "in_ready with packet held", in_ready, 0);
    out_en_n = 1'b0;
    wait_pkts(base + 1);
    chk(pkt_cnt == base + 1, "R8", "burst after enable", pkt_cnt, base + 1);
    cmp_last(90, 1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_abort;
    int base = pkt_cnt;
    int tr = trunc_cnt;
    out_en_n = 1'b0;
    send_pkt(120, 1'b0, 1'b1);
    for (int i = 0; i < 500; i++) begin
      if (cur_len >= 40) break;
      @(posedge clk); #1;
    end
    out_en_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0 && out_err_n == 1 && out_data == 0, "R8", "outputs idle after disable",
        {out_data, out_valid, out_err_n}, 1);
    repeat (20) @(posedge clk);
    #1;
    chk(trunc_cnt == tr + 1, "R8", "cut-short bursts", trunc_cnt, tr + 1);
    chk(in_ready == 1, "R9", "in_ready after drop", in_ready, 1);
    out_en_n = 1'b0;
    repeat (250) @(posedge clk);
    #1;
    chk(pkt_cnt == base, "R8", "dropped burst not resumed", pkt_cnt, base);
    send_pkt(121, 1'b0, 1'b0);
    wait_pkts(base + 1);
    cmp_last(121, 1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_invariants;
    chk(gap_viol == 0, "R2", "gap cycles not idle", gap_viol, 0);
    chk(start_viol == 0, "R3", "misplaced start strobes", start_viol, 0);
    chk(long_viol == 0, "R4", "bytes beyond packet length", long_viol, 0);
    chk(edge_viol == 0, "R11", "changes across rising edge", edge_viol, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_clean_pkt();
    t_bad_marked();
    t_bad_unmarked();
    t_clean_preset();
    t_junk_before_sop();
    t_held_while_disabled();
    t_abort();
    repeat (5) @(posedge clk);
    t_invariants();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule